// File: doc/BRIEF.md
# Greyscale Step Pulse Generator

This block drives the greyscale step clock of a multiplexed vacuum fluorescent panel. The panel drivers hold a per-pixel 3-bit brightness code and advance an internal PWM step on each pulse of this clock. The step sequence is cleared while the blanking signal is high. During the unblanked part of every scan, the block emits six short pulses. Each pulse is placed at its own programmable distance from the end of blanking. The default schedule packs the pulses closer together as the next blanking interval approaches, which gives the eight brightness levels a roughly logarithmic, eye-matched response.

The block counts system clocks from the falling edge of the blanking input. It compares the count against the offset register of the step that comes next. Software rewrites the six offsets through a simple write port. If blanking returns before all six pulses have been emitted, the remaining pulses are dropped and a missed flag is raised for the rest of that blanking interval.

Top module: `gcp_pulse_gen`

## Requirements
- R1: After reset, `gcp_o` and `missed_o` are low and the six offsets take their default values (see R8).
- R2: Pulse k (k = 0..5) starts one cycle after the rising clock edge that is the off_k-th edge at which `blank_i` is sampled low within the current window, counting that first low edge as 1. No more than six pulses are emitted per window.
- R3: Each pulse stays high for exactly PULSE_W clock cycles, provided `blank_i` stays low for that long.
- R4: `gcp_o` is never high while `blank_i` is high. A high `blank_i` returns the sequence to its first step, so the first pulse of the next window uses offset 0.
- R5: If `blank_i` rises while fewer than six pulses have been emitted, `missed_o` goes high after the first edge that samples `blank_i` high. It stays high through the blanking interval and clears after the first low-sampled edge of the next window. A window that completes all six pulses leaves `missed_o` low.
- R6: Offsets must be strictly increasing and at least 1. If an offset is not greater than the one before it, its step never matches, so neither that pulse nor any later pulse in the window is emitted.
- R7: When `cfg_we` is high at a clock edge, offset register `cfg_sel` (values 0..5) is loaded with `cfg_val`. Writes with `cfg_sel` equal to 6 or 7 change no offset.
- R8: The default offsets are cumulative gaps of 4, 3, 2, 2, 1.5 and 1 times UNIT clocks. With UNIT = 1800 this gives 7200, 12600, 16200, 19800, 22500 and 24300.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blank_i | input | 1 | Panel blanking, high = blanked |
| cfg_we | input | 1 | Offset register write strobe |
| cfg_sel | input | 3 | Offset register index (0..5 valid) |
| cfg_val | input | OFS_W | Offset value in clocks after blanking ends |
| gcp_o | output | 1 | Greyscale step clock to the panel drivers |
| missed_o | output | 1 | Window ended before all six pulses |

## Verification
The default schedule is run over one full scan after reset to confirm that the shrinking-gap placement matches the configured ratios. Random strictly increasing offset sets with random window lengths are then applied. Windows long enough for all six pulses confirm the exact start edges and that the flag stays low. Truncated windows show which pulses are dropped and confirm that the flag rises. Directed cases cover an offset of 1 (a pulse on the first low edge), a non-increasing offset that stalls the sequence, and writes to the unused indices, which must leave the timing of the next scan unchanged.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
  localparam int NUM_STEPS = 6;

  // Cumulative half-unit position of step k in the default schedule.
  function automatic int unsigned default_halves(input int k);
    case (k)
      0:       return 8;
      1:       return 14;
      2:       return 18;
      3:       return 22;
      4:       return 25;
      default: return 27;
    endcase
  endfunction

  function automatic int unsigned default_offset(input int k, input int unsigned unit);
    return default_halves(k) * unit / 2;
  endfunction
endpackage

// File: rtl/gcp_window_timer.sv
module gcp_window_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_i,
  output logic [CNT_W-1:0] cnt_next,
  output logic             blank_rise,
  output logic             blank_fall
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             blank_q;

  // Saturating count of low-sampled edges in the current window.
  assign cnt_next   = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign blank_rise = blank_i && !blank_q;
  assign blank_fall = !blank_i && blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      blank_q <= 1'b1;
    end else begin
      blank_q <= blank_i;
      cnt     <= blank_i ? '0 : cnt_next;
    end
  end

  assert_count_from_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    blank_fall |=> (cnt == CNT_W'(1)));
endmodule

// File: rtl/gcp_offset_regs.sv
module gcp_offset_regs
  import gcp_pkg::*;
#(
  parameter int          OFS_W = 16,
  parameter int unsigned UNIT  = 1800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [OFS_W-1:0] cfg_val,
  input  logic [2:0]       step,
  output logic [OFS_W-1:0] cur_off
);
  logic [OFS_W-1:0] ofs_q [NUM_STEPS];

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_ofs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ofs_q[k] <= OFS_W'(default_offset(k, UNIT));
      else if (cfg_we && cfg_sel == 3'(k))  ofs_q[k] <= cfg_val;
    end

    assert_untouched_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel != 3'(k)) |=> (ofs_q[k] == $past(ofs_q[k])));
  end

  always_comb begin
    cur_off = '0;
    for (int i = 0; i < NUM_STEPS; i++)
      if (step == 3'(i)) cur_off = ofs_q[i];
  end
endmodule

// File: rtl/gcp_step_seq.sv
module gcp_step_seq
  import gcp_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int PULSE_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_i,
  input  logic             blank_rise,
  input  logic             blank_fall,
  input  logic [OFS_W-1:0] cnt_next,
  input  logic [OFS_W-1:0] cur_off,
  output logic [2:0]       step,
  output logic             fire,
  output logic             gcp_q,
  output logic             missed_o
);
  localparam int PW_W = $clog2(PULSE_W + 1);
  localparam logic [2:0] LAST = 3'(NUM_STEPS);

  logic [PW_W-1:0] pw_left;
  logic            steps_left;

  assign steps_left = (step < LAST);
  assign fire       = !blank_i && steps_left && (cnt_next == cur_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= '0;
      gcp_q    <= 1'b0;
      pw_left  <= '0;
      missed_o <= 1'b0;
    end else begin
      if (blank_i)   step <= '0;
      else if (fire) step <= step + 1'b1;

      if (fire) begin
        gcp_q   <= 1'b1;
        pw_left <= PW_W'(PULSE_W - 1);
      end else if (blank_i) begin
        gcp_q   <= 1'b0;
        pw_left <= '0;
      end else if (pw_left != '0) begin
        pw_left <= pw_left - 1'b1;
      end else begin
        gcp_q   <= 1'b0;
      end

      if (blank_rise && steps_left) missed_o <= 1'b1;
      else if (blank_fall)          missed_o <= 1'b0;
    end
  end

  assert_pulse_on_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (gcp_q && step == $past(step) + 3'd1));
  assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST);
  assert_width_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gcp_q && pw_left != '0 && !blank_i) |=> gcp_q);
  assert_step_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |=> (step == 3'd0));
  assert_missed_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_rise && steps_left) |=> missed_o);
endmodule

// File: rtl/gcp_pulse_gen.sv
module gcp_pulse_gen #(
  parameter int          OFS_W   = 16,
  parameter int          PULSE_W = 13,
  parameter int unsigned UNIT    = 1800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_i,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [OFS_W-1:0] cfg_val,
  output logic             gcp_o,
  output logic             missed_o
);
  logic [OFS_W-1:0] cnt_next;
  logic [OFS_W-1:0] cur_off;
  logic [2:0]       step;
  logic             blank_rise, blank_fall, fire, gcp_q;

  gcp_window_timer #(.CNT_W(OFS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .blank_i(blank_i),
    .cnt_next(cnt_next), .blank_rise(blank_rise), .blank_fall(blank_fall)
  );

  gcp_offset_regs #(.OFS_W(OFS_W), .UNIT(UNIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_val(cfg_val), .step(step), .cur_off(cur_off)
  );

  gcp_step_seq #(.OFS_W(OFS_W), .PULSE_W(PULSE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .blank_i(blank_i), .blank_rise(blank_rise),
    .blank_fall(blank_fall), .cnt_next(cnt_next), .cur_off(cur_off),
    .step(step), .fire(fire), .gcp_q(gcp_q), .missed_o(missed_o)
  );

  // Blanking cuts a running pulse without waiting for the next edge.
  assign gcp_o = gcp_q && !blank_i;

  assert_fire_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !blank_rise);
endmodule

// File: tb/test_gcp_pulse_gen.sv
module test_gcp_pulse_gen;
  localparam int OFS_W = 16;
  localparam int PW    = 13;
  localparam int UNIT  = 1800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blank_i = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [OFS_W-1:0] cfg_val = '0;
  logic gcp_o, missed_o;

  int compared = 0;
  int mismatched = 0;
  int model_off [6];
  int got [6];
  int exp_t [6];
  int rises, first_len;
  bit done = 0;

  always #4 clk = ~clk;

  gcp_pulse_gen #(.OFS_W(OFS_W), .PULSE_W(PW), .UNIT(UNIT)) i_gcp_pulse_gen (
    .clk(clk), .rst_n(rst_n), .blank_i(blank_i), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_val(cfg_val), .gcp_o(gcp_o), .missed_o(missed_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Default schedule restated as gaps in half units.
  function automatic int def_off(input int k);
    int gaps [6] = '{8, 6, 4, 4, 3, 2};
    int s = 0;
    for (int i = 0; i <= k; i++) s += gaps[i];
    return s * (UNIT / 2);
  endfunction

  // Expected start edges: a step fires only above the previous firing edge.
  function automatic int predict(input int low_len);
    int t = 0;
    int n = 0;
    for (int k = 0; k < 6; k++) exp_t[k] = -1;
    for (int k = 0; k < 6; k++) begin
      if (model_off[k] > t && model_off[k] <= low_len) begin
        exp_t[k] = model_off[k];
        t = model_off[k];
        n++;
      end else break;
    end
    return n;
  endfunction

  task automatic write_off(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_val = OFS_W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 6) model_off[sel] = val;
  endtask

  task automatic run_scan(input int low_len, input string tag);
    logic prev = 1'b0;
    int n_exp;
    for (int k = 0; k < 6; k++) got[k] = -1;
    rises = 0; first_len = 0;
    @(negedge clk);
    blank_i = 1'b0;
    for (int n = 1; n <= low_len; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == 1) check(missed_o == 1'b0, "R5 flag clears in new window", int'(missed_o), 0);
      if (gcp_o && !prev) begin
        if (rises < 6) got[rises] = n;
        rises++;
      end
      if (rises == 1 && gcp_o) first_len++;
      prev = gcp_o;
    end
    blank_i = 1'b1;
    #1;
    check(gcp_o == 1'b0, "R4 output drops with blank", int'(gcp_o), 0);
    for (int j = 0; j < 4; j++) begin
      @(posedge clk); @(negedge clk);
      check(gcp_o == 1'b0, "R4 no pulse in blank", int'(gcp_o), 0);
    end
    n_exp = predict(low_len);
    check(rises == n_exp, {"R2 pulse count ", tag}, rises, n_exp);
    for (int k = 0; k < 6; k++)
      check(got[k] == exp_t[k], {"R2 start edge ", tag}, got[k], exp_t[k]);
    check(missed_o == (n_exp < 6), {"R5 missed flag ", tag}, int'(missed_o), int'(n_exp < 6));
  endtask

  initial begin
    #1_600_000;
    mismatched++; compared++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int t, len;
    void'($urandom(32'd7331));
    for (int k = 0; k < 6; k++) model_off[k] = def_off(k);
    repeat (3) @(negedge clk);
    check(gcp_o == 1'b0, "R1 gcp after reset", int'(gcp_o), 0);
    check(missed_o == 1'b0, "R1 missed after reset", int'(missed_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1/R8: default shrinking schedule over one full scan.
    run_scan(def_off(5) + PW + 5, "R8 default");
    check(first_len == PW, "R3 pulse width", first_len, PW);

    // Directed: offset 1 fires on the first low edge.
    write_off(0, 1); write_off(1, 30); write_off(2, 50);
    write_off(3, 70); write_off(4, 85); write_off(5, 99);
    run_scan(99 + PW + 3, "offset one");
    check(first_len == PW, "R3 pulse width short", first_len, PW);

    // R7: writes to unused indices leave the schedule unchanged.
    write_off(6, 5); write_off(7, 3);
    run_scan(99 + PW + 3, "R7 ignored sel");

    // R5: window cut after third pulse.
    run_scan(60, "R5 truncated");
    // R4: sequence restarts at step 0 after truncation.
    run_scan(99 + PW + 3, "R4 restart");

    // R6: non-increasing offset stalls the rest.
    write_off(3, 40);
    run_scan(120, "R6 stall");
    write_off(3, 70);

    // Random schedules, full and truncated windows.
    for (int s = 0; s < 24; s++) begin
      t = 0;
      for (int k = 0; k < 6; k++) begin
        t += PW + 1 + int'($urandom % 40);
        write_off(k, t);
      end
      if ($urandom % 3 == 0) len = 1 + int'($urandom % t);
      else len = t + PW + 2 + int'($urandom % 10);
      run_scan(len, "random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule